// File: doc/BRIEF.md
# Timed Register Write Pattern Player

This block replays a waveform kept in a small pattern memory onto one register of a parallel port. The memory holds bytes in pairs: the even byte of each pair is a value to write and the odd byte is how long, in microseconds, to hold that value before the next pair is taken. On a start pulse the block latches which port register to target and how many pattern bytes to use. It then fetches each pair, issues one write strobe carrying the value and the latched register address, and holds for the dwell time. It repeats this until the list is used up, then pulses done. The whole waveform runs with no host action between steps, so control lines can be toggled with microsecond-accurate spacing.

The microsecond time base comes from a clock divider set by `CLKS_PER_US`. The divider is cleared on every write strobe, so each dwell is measured from its own write. The pattern memory is read through a plain synchronous port: `mem_rd_en` with `mem_addr` in one cycle, `mem_rdata` valid in the next. The register write is a one-cycle strobe with no back-pressure. The register side must take a write in the cycle it is offered. Loading the pattern memory and reading the port back are handled elsewhere.

Top module: `pp_pattern_player`

## Requirements
- R1: While reset is held and after it is released, `busy`, `done`, `wr_valid` and `mem_rd_en` are low until a start pulse is seen, and no read or write happens while `busy` is low.
- R2: A start pulse seen while idle latches `reg_sel` and `pair_len`. Every write of that run carries the latched `reg_sel` on `wr_addr`, even if `reg_sel` changes later. Memory reads return data in the cycle after `mem_rd_en`.
- R3: Pairs are played in address order from byte 0: pair k writes the byte at address 2k on `wr_data` and uses the byte at address 2k+1 as its dwell in microseconds (0 to 255).
- R4: With a dwell D greater than zero, the next write follows its predecessor by exactly D*CLKS_PER_US+3 clock cycles. The divider restarts at each write strobe.
- R5: A dwell of 0 adds no wait: the fetch of the next pair starts on the cycle after the write, giving a spacing of 3 cycles between writes.
- R6: `pair_len` counts bytes. An odd length plays floor(pair_len/2) pairs, and the trailing byte is never written.
- R7: A `pair_len` of 0 or 1 produces `done` in the cycle after start, with no memory read and no write.
- R8: `done` is a single-cycle pulse that comes D*CLKS_PER_US+1 cycles after the final write (D being the final dwell). `busy` is low in the cycle after `done`.
- R9: A start pulse that arrives while `busy` is high and `done` is low is ignored. It does not alter the run, the target register or the pair count, and it does not start a second run.
- R10: `busy` rises in the cycle after the start pulse is sampled, and the first write appears 3 cycles after that sample.
- R11: `wr_valid` is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run; taken only while idle |
| reg_sel | input | REG_W | Target port register for the run |
| pair_len | input | ADDR_W+1 | Number of pattern bytes to use (at most 2^ADDR_W) |
| mem_rd_en | output | 1 | Pattern memory read request |
| mem_addr | output | ADDR_W | Pattern memory byte address |
| mem_rdata | input | DATA_W | Pattern memory data, valid the cycle after a read |
| wr_valid | output | 1 | Register write strobe, one cycle |
| wr_addr | output | REG_W | Register address of the write |
| wr_data | output | DATA_W | Value written |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle pulse at the end of a run |

## Verification
On every cycle the checker confirms that reads and writes occur only while busy, that writes are isolated single-cycle strobes preceded by a memory read, that every write targets the register captured at start, that done is a lone pulse followed by idle, that a start during a run keeps the block busy, and that an empty or one-byte list ends in the next cycle. The exact spacing between writes for each dwell value, the byte order of pairs, and the handling of an odd trailing byte depend on the memory contents. These only show up in the bench's scenarios, where random pattern lists and directed cases (dwell 0, dwell 255, odd lengths, a start during a run) are compared against timing worked out from the dwell bytes.

// File: rtl/pp_pattern_pkg.sv
package pp_pattern_pkg;

  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_RD_DATA  = 3'd1,
    ST_RD_DWELL = 3'd2,
    ST_WRITE    = 3'd3,
    ST_WAIT     = 3'd4,
    ST_DONE     = 3'd5
  } player_state_e;

  // Width of a counter able to hold values 0..n-1, at least one bit.
  function automatic int unsigned cnt_width(input int unsigned n);
    return (n <= 2) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/pp_us_tick.sv
module pp_us_tick #(
  parameter int unsigned CLKS_PER_US = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic enable,
  output logic tick
);
  localparam int unsigned CNT_W = pp_pattern_pkg::cnt_width(CLKS_PER_US);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CLKS_PER_US - 1);

  generate
    if (CLKS_PER_US <= 1) begin : g_direct
      assign tick = enable && !restart;
    end else begin : g_divide
      logic [CNT_W-1:0] cnt_q;

      assign tick = enable && !restart && (cnt_q == LAST);

      always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
          cnt_q <= '0;
        end else if (enable) begin
          cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
        end
      end
    end
  endgenerate

endmodule

// File: rtl/pp_dwell_timer.sv
module pp_dwell_timer #(
  parameter int unsigned CLKS_PER_US = 100,
  parameter int unsigned DWELL_W     = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [DWELL_W-1:0] load_val,
  input  logic               run,
  output logic               expire
);
  logic               us_tick;
  logic [DWELL_W-1:0] left_q;

  pp_us_tick #(.CLKS_PER_US(CLKS_PER_US)) i_tick (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (load),
    .enable  (run),
    .tick    (us_tick)
  );

  assign expire = us_tick && (left_q == DWELL_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      left_q <= '0;
    end else if (load) begin
      left_q <= load_val;
    end else if (us_tick && left_q != '0) begin
      left_q <= left_q - 1'b1;
    end
  end

endmodule

// File: rtl/pp_step_sequencer.sv
module pp_step_sequencer
  import pp_pattern_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned REG_W  = 3,
  localparam int unsigned LEN_W = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [REG_W-1:0]  reg_sel,
  input  logic [LEN_W-1:0]  pair_len,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              dwell_expire,
  output logic              mem_rd_en,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              wr_valid,
  output logic [REG_W-1:0]  wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              dwell_load,
  output logic [DATA_W-1:0] dwell_value,
  output logic              wait_active,
  output logic              busy,
  output logic              done
);
  player_state_e     state_q, state_d;
  logic [ADDR_W-1:0] base_q;
  logic [ADDR_W-1:0] left_q;
  logic [REG_W-1:0]  reg_q;
  logic [DATA_W-1:0] data_q;
  logic [LEN_W-1:0]  pairs_full;
  logic [ADDR_W-1:0] pairs_in;
  logic              last_pair;
  logic              step_adv;
  logic              zero_dwell;

  assign pairs_full = pair_len >> 1;
  assign pairs_in   = ADDR_W'(pairs_full);
  assign last_pair  = (left_q == ADDR_W'(1));
  assign zero_dwell = (mem_rdata == '0);
  assign step_adv   = ((state_q == ST_WRITE) && zero_dwell) ||
                      ((state_q == ST_WAIT) && dwell_expire);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:     if (start) state_d = (pairs_full == '0) ? ST_DONE : ST_RD_DATA;
      ST_RD_DATA:  state_d = ST_RD_DWELL;
      ST_RD_DWELL: state_d = ST_WRITE;
      ST_WRITE: begin
        if (!zero_dwell)    state_d = ST_WAIT;
        else if (last_pair) state_d = ST_DONE;
        else                state_d = ST_RD_DATA;
      end
      ST_WAIT: begin
        if (dwell_expire) state_d = last_pair ? ST_DONE : ST_RD_DATA;
      end
      ST_DONE:     state_d = ST_IDLE;
      default:     state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      base_q  <= '0;
      left_q  <= '0;
      reg_q   <= '0;
      data_q  <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_IDLE && start) begin
        reg_q  <= reg_sel;
        left_q <= pairs_in;
        base_q <= '0;
      end
      if (state_q == ST_RD_DWELL) begin
        data_q <= mem_rdata;
      end
      if (step_adv) begin
        left_q <= left_q - 1'b1;
        base_q <= base_q + ADDR_W'(2);
      end
    end
  end

  assign mem_rd_en   = (state_q == ST_RD_DATA) || (state_q == ST_RD_DWELL);
  assign mem_addr    = base_q + ADDR_W'(state_q == ST_RD_DWELL);
  assign wr_valid    = (state_q == ST_WRITE);
  assign wr_addr     = reg_q;
  assign wr_data     = data_q;
  assign dwell_load  = (state_q == ST_WRITE);
  assign dwell_value = mem_rdata;
  assign wait_active = (state_q == ST_WAIT);
  assign busy        = (state_q != ST_IDLE);
  assign done        = (state_q == ST_DONE);

endmodule

// File: rtl/pp_pattern_player.sv
module pp_pattern_player #(
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned REG_W       = 3,
  parameter int unsigned CLKS_PER_US = 100,
  localparam int unsigned LEN_W      = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [REG_W-1:0]  reg_sel,
  input  logic [LEN_W-1:0]  pair_len,
  output logic              mem_rd_en,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              wr_valid,
  output logic [REG_W-1:0]  wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              busy,
  output logic              done
);
  logic              dwell_load;
  logic [DATA_W-1:0] dwell_value;
  logic              wait_active;
  logic              dwell_expire;

  pp_step_sequencer #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .REG_W  (REG_W)
  ) i_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (start),
    .reg_sel      (reg_sel),
    .pair_len     (pair_len),
    .mem_rdata    (mem_rdata),
    .dwell_expire (dwell_expire),
    .mem_rd_en    (mem_rd_en),
    .mem_addr     (mem_addr),
    .wr_valid     (wr_valid),
    .wr_addr      (wr_addr),
    .wr_data      (wr_data),
    .dwell_load   (dwell_load),
    .dwell_value  (dwell_value),
    .wait_active  (wait_active),
    .busy         (busy),
    .done         (done)
  );

  pp_dwell_timer #(
    .CLKS_PER_US (CLKS_PER_US),
    .DWELL_W     (DATA_W)
  ) i_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (dwell_load),
    .load_val (dwell_value),
    .run      (wait_active),
    .expire   (dwell_expire)
  );

endmodule

// File: rtl/pp_pattern_player_chk.sv
module pp_pattern_player_chk #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned REG_W  = 3,
  localparam int unsigned LEN_W = ADDR_W + 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic [REG_W-1:0] reg_sel,
  input logic [LEN_W-1:0] pair_len,
  input logic             mem_rd_en,
  input logic             wr_valid,
  input logic [REG_W-1:0] wr_addr,
  input logic             busy,
  input logic             done
);
  logic [REG_W-1:0] run_reg_q;

  always_ff @(posedge clk) begin
    if (!rst_n)              run_reg_q <= '0;
    else if (start && !busy) run_reg_q <= reg_sel;
  end

  assert_quiet_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!wr_valid && !mem_rd_en && !done));

  assert_target_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> (wr_addr == run_reg_q));

  assert_fetch_before_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> $past(mem_rd_en));

  assert_empty_list_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && pair_len < LEN_W'(2)) |=> done);

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));

  assert_start_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done && start) |=> busy);

  assert_busy_rise_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

  assert_single_strobe_R11: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |=> !wr_valid);

endmodule

bind pp_pattern_player pp_pattern_player_chk #(
  .ADDR_W (ADDR_W),
  .REG_W  (REG_W)
) i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .reg_sel   (reg_sel),
  .pair_len  (pair_len),
  .mem_rd_en (mem_rd_en),
  .wr_valid  (wr_valid),
  .wr_addr   (wr_addr),
  .busy      (busy),
  .done      (done)
);

// File: tb/test_pp_pattern_player.sv
`timescale 1ns/1ps
module test_pp_pattern_player;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 8;
  localparam int REG_W  = 3;
  localparam int DIV    = 5;
  localparam int LEN_W  = ADDR_W + 1;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              start = 1'b0;
  logic [REG_W-1:0]  reg_sel = '0;
  logic [LEN_W-1:0]  pair_len = '0;
  logic              mem_rd_en;
  logic [ADDR_W-1:0] mem_addr;
  logic [DATA_W-1:0] mem_rdata = '0;
  logic              wr_valid;
  logic [REG_W-1:0]  wr_addr;
  logic [DATA_W-1:0] wr_data;
  logic              busy;
  logic              done;

  logic [7:0] mem [256];
  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  always_ff @(posedge clk) begin
    if (mem_rd_en) mem_rdata <= mem[mem_addr];
  end

  pp_pattern_player #(
    .ADDR_W (ADDR_W), .DATA_W (DATA_W), .REG_W (REG_W), .CLKS_PER_US (DIV)
  ) i_pp_pattern_player (
    .clk (clk), .rst_n (rst_n), .start (start), .reg_sel (reg_sel),
    .pair_len (pair_len), .mem_rd_en (mem_rd_en), .mem_addr (mem_addr),
    .mem_rdata (mem_rdata), .wr_valid (wr_valid), .wr_addr (wr_addr),
    .wr_data (wr_data), .busy (busy), .done (done)
  );

  function automatic int write_gap(input int dwell);
    return dwell * DIV + 3;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Plays one list and compares every write and the done pulse to timing
  // derived from the dwell bytes. inject_at > 0 pulses start mid-run.
  task automatic run_list(input int len, input int rsel, input int inject_at);
    int pairs = len / 2;
    int exp_t = 3;
    int k = 0;
    int t = 0;
    bit fin = 0;
    bit prev_zero = 0;
    @(negedge clk);
    start = 1'b1; reg_sel = REG_W'(rsel); pair_len = LEN_W'(len);
    while (!fin && t < 20000) begin
      @(negedge clk);
      t++;
      if (t == 1) begin
        start = 1'b0;
        check(busy == 1'b1, "R10", "busy after start", int'(busy), 1);
      end
      if (inject_at > 0 && t == inject_at) begin
        start = 1'b1; reg_sel = REG_W'(rsel ^ 1); pair_len = LEN_W'(2);
      end else if (inject_at > 0 && t == inject_at + 1) begin
        start = 1'b0; reg_sel = REG_W'(rsel ^ 2);
      end
      if (pairs == 0 && (mem_rd_en || wr_valid))
        check(1'b0, "R7", "access on empty list", 1, 0);
      if (wr_valid) begin
        check(k < pairs, "R6", "write count", k + 1, pairs);
        if (k < pairs) begin
          if (k == 0)         check(t == exp_t, "R10", "first write cycle", t, exp_t);
          else if (prev_zero) check(t == exp_t, "R5", "zero dwell spacing", t, exp_t);
          else                check(t == exp_t, "R4", "dwell spacing", t, exp_t);
          check(wr_data == mem[2*k], "R3", "write data", int'(wr_data), int'(mem[2*k]));
          check(int'(wr_addr) == rsel, "R2", "write target", int'(wr_addr), rsel);
          prev_zero = (mem[2*k+1] == 8'd0);
          exp_t = t + write_gap(int'(mem[2*k+1]));
          k++;
        end
      end
      if (done) begin
        if (pairs == 0) check(t == 1, "R7", "empty done cycle", t, 1);
        else            check(t == exp_t - 2, "R8", "done cycle", t, exp_t - 2);
        check(k == pairs, "R6", "pairs played", k, pairs);
        fin = 1;
      end
    end
    if (!fin) check(1'b0, "R8", "run timeout", t, 0);
    @(negedge clk);
    check(!busy && !done, inject_at > 0 ? "R9" : "R8", "idle after done",
          int'(busy) + int'(done), 0);
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL R8 watchdog expired: actual 1 expected 0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd7341));
    for (int i = 0; i < 256; i++) mem[i] = 8'($urandom);
    repeat (3) @(negedge clk);
    check(!busy && !done && !wr_valid && !mem_rd_en, "R1", "reset outputs",
          int'(busy) + int'(done) + int'(wr_valid) + int'(mem_rd_en), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(!busy && !done && !wr_valid && !mem_rd_en, "R1", "idle outputs",
          int'(busy) + int'(done) + int'(wr_valid) + int'(mem_rd_en), 0);

    // Directed corners
    for (int i = 0; i < 16; i++) mem[2*i+1] = 8'(i % 3);
    run_list(0, 2, 0);                 // R7 empty list
    run_list(1, 3, 0);                 // R7 single byte
    mem[1] = 8'd0; mem[3] = 8'd0; mem[5] = 8'd0;
    run_list(6, 5, 0);                 // R5 all zero dwells
    run_list(7, 6, 0);                 // R6 odd length
    mem[1] = 8'd255; mem[3] = 8'd1;
    run_list(4, 1, 0);                 // R4 max dwell
    mem[1] = 8'd4; mem[3] = 8'd2; mem[5] = 8'd3;
    run_list(6, 4, 7);                 // R9 start while busy

    // Random lists with short dwells
    for (int n = 0; n < 25; n++) begin
      for (int i = 0; i < 128; i++) mem[2*i+1] = 8'($urandom_range(0, 6));
      run_list(int'($urandom_range(0, 40)), int'($urandom_range(0, 7)),
               (n % 5 == 0) ? int'($urandom_range(2, 9)) : 0);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule